// File: doc/BRIEF.md
# Line Burst Read Front End

This block sits between a consumer and a word-wide cache data array with single-cycle combinational read. One start strobe with a byte address starts a burst. The block reads the four words of the aligned line that holds that address, lowest word first. The consumer sends no further addresses, because the block keeps its own beat counter.

A registered output stage presents the current word. While the consumer looks at that word, the array is already being addressed with the following word of the line. When the consumer accepts a word, the prefetched word moves into the register on the same edge. The first word appears one clock after the start cycle, and each later word follows one clock after the previous one is accepted. Over a line this gives a 2-1-1-1 pattern. A scheme that sends an address for every word needs about three clocks per word.

Top module: `burst_rd_fe`

## Requirements
- R1: While reset is asserted, and after its release until the first start, `valid_o` is 0 and `data_o` is 0.
- R2: A cycle with `start_i` high is followed in the next cycle by `valid_o` high, with `data_o` holding the array word at the base of the addressed line.
- R3: The line base is the word address `addr_i >> 2` with its two low bits cleared. The low four byte-address bits do not select the first word, and `arr_addr_o` equals this base during the start cycle.
- R4: While `valid_o` is high, a cycle with `ack_i` high and no start replaces `data_o` with the next word of the line in the next cycle. With `ack_i` held high, the four words of the line appear in four consecutive cycles.
- R5: While `valid_o` is high, a cycle with `ack_i` low and no start leaves `valid_o` high and `data_o` unchanged in the next cycle.
- R6: Once the fourth word of a burst is accepted, `valid_o` is 0 in the next cycle and stays 0 until the next start.
- R7: A start during a burst abandons that burst. The next cycle shows word 0 of the new line, and four full words of the new line follow.
- R8: When `start_i` and `ack_i` are high in the same cycle, the start takes priority over the accept.
- R9: While `valid_o` is 0, `ack_i` has no effect: `valid_o` stays 0 and `data_o` keeps its value.
- R10: During a burst, every array address stays inside the captured line. Only the two low bits of the word address change, and they wrap within the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, samples `addr_i` |
| addr_i | input | 16 | Byte address inside the wanted line |
| ack_i | input | 1 | Consumer accepts the word on `data_o` |
| data_o | output | 32 | Current burst word |
| valid_o | output | 1 | `data_o` holds a word of the current burst |
| arr_addr_o | output | 14 | Word address to the data array |
| arr_rdata_i | input | 32 | Array read data for `arr_addr_o`, same cycle |

## Verification
The assertions check the cycle relations on every cycle:
- a start raises `valid_o` on the next cycle;
- a stall, or an accept while idle, leaves the output word unchanged;
- the line bits of the array address hold still for the whole burst;
- `valid_o` drops exactly after the fourth accepted word.

Only the bench scenarios can show which word values arrive and in which order. Those scenarios cover the line base being chosen from an unaligned address, aborted bursts, and a start that collides with an accept.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_STREAM = 1'b1
  } rd_state_e;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/burst_rd_ctrl.sv
module burst_rd_ctrl
  import burst_rd_pkg::*;
#(
  parameter int unsigned LINE_WORDS = 4,
  localparam int unsigned BEAT_W = clog2_min1(LINE_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ack_i,
  output logic              valid_o,
  output logic              load_o,
  output logic [BEAT_W-1:0] beat_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LINE_WORDS - 1);

  rd_state_e   state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic        take, last;

  assign take = (state_q == ST_STREAM) && ack_i;
  assign last = (beat_q == LAST_BEAT);

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    load_o  = 1'b0;
    if (start_i) begin
      // start wins over any accept in the same cycle
      state_d = ST_STREAM;
      beat_d  = '0;
      load_o  = 1'b1;
    end else if (take) begin
      if (last) begin
        state_d = ST_IDLE;
      end else begin
        beat_d = beat_q + 1'b1;
        load_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  assign valid_o = (state_q == ST_STREAM);
  assign beat_o  = beat_q;
endmodule

// File: rtl/burst_rd_addr.sv
module burst_rd_addr #(
  parameter int unsigned WA_W   = 14,
  parameter int unsigned BEAT_W = 2,
  localparam int unsigned LINE_W = WA_W - BEAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WA_W-1:0]   start_word_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [WA_W-1:0]   arr_addr_o
);
  logic [LINE_W-1:0] line_q;
  logic [BEAT_W-1:0] next_beat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else if (start_i) line_q <= start_word_i[WA_W-1:BEAT_W];
  end

  // prefetch address: word after the one in the output register, wraps in line
  assign next_beat = beat_i + 1'b1;

  always_comb begin
    if (start_i) arr_addr_o = {start_word_i[WA_W-1:BEAT_W], {BEAT_W{1'b0}}};
    else         arr_addr_o = {line_q, next_beat};
  end
endmodule

// File: rtl/burst_rd_oreg.sv
module burst_rd_oreg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/burst_rd_fe.sv
module burst_rd_fe
  import burst_rd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LINE_WORDS = 4,
  localparam int unsigned BYTE_W = $clog2(DATA_W / 8),
  localparam int unsigned WA_W   = ADDR_W - BYTE_W,
  localparam int unsigned BEAT_W = clog2_min1(LINE_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic [WA_W-1:0]   arr_addr_o,
  input  logic [DATA_W-1:0] arr_rdata_i
);
  logic              load;
  logic [BEAT_W-1:0] beat;
  logic [WA_W-1:0]   start_word;

  assign start_word = addr_i[ADDR_W-1:BYTE_W];

  burst_rd_ctrl #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .ack_i   (ack_i),
    .valid_o (valid_o),
    .load_o  (load),
    .beat_o  (beat)
  );

  burst_rd_addr #(.WA_W(WA_W), .BEAT_W(BEAT_W)) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_word_i (start_word),
    .beat_i       (beat),
    .arr_addr_o   (arr_addr_o)
  );

  burst_rd_oreg #(.DATA_W(DATA_W)) u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .d_i    (arr_rdata_i),
    .q_o    (data_o)
  );
endmodule

// File: rtl/burst_rd_fe_chk.sv
module burst_rd_fe_chk #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned WA_W       = 14,
  parameter int unsigned LINE_WORDS = 4,
  localparam int unsigned BEAT_W = (LINE_WORDS <= 2) ? 1 : $clog2(LINE_WORDS),
  localparam int unsigned CNT_W  = BEAT_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ack_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] data_o,
  input logic [WA_W-1:0]   arr_addr_o
);
  logic [CNT_W-1:0] taken_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) taken_q <= '0;
    else if (start_i) taken_q <= '0;
    else if (valid_o && ack_i) taken_q <= taken_q + 1'b1;
  end

  p_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);

  p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ack_i && !start_i) |=> (valid_o && $stable(data_o)));

  p_idle_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !start_i) |=> (!valid_o && $stable(data_o)));

  p_line_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i) |=> (start_i || $stable(arr_addr_o[WA_W-1:BEAT_W])));

  p_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ack_i && !start_i && taken_q == CNT_W'(LINE_WORDS - 1)) |=> !valid_o);

  p_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (taken_q < CNT_W'(LINE_WORDS)));
endmodule

bind burst_rd_fe burst_rd_fe_chk #(
  .DATA_W(DATA_W), .WA_W(WA_W), .LINE_WORDS(LINE_WORDS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .ack_i      (ack_i),
  .valid_o    (valid_o),
  .data_o     (data_o),
  .arr_addr_o (arr_addr_o)
);

// File: tb/burst_rd_fe_bench.sv
module burst_rd_fe_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] addr = '0;
  logic        ack = 1'b0;
  logic [31:0] data;
  logic        valid;
  logic [13:0] arr_addr;
  logic [31:0] arr_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [31:0] word_of(input logic [13:0] a);
    return {a, 2'b01, ~a, 2'b10};
  endfunction

  assign arr_rdata = word_of(arr_addr);

  burst_rd_fe u_burst_rd_fe (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .addr_i      (addr),
    .ack_i       (ack),
    .data_o      (data),
    .valid_o     (valid),
    .arr_addr_o  (arr_addr),
    .arr_rdata_i (arr_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // {byte address, stall mask: bit k adds one stall before accepting word k}
  localparam logic [19:0] VEC [6] = '{
    {16'h0000, 4'b0000},
    {16'h1237, 4'b0000},
    {16'h00F4, 4'b0001},
    {16'hABCD, 4'b1010},
    {16'hFFFF, 4'b1111},
    {16'h4008, 4'b0100}
  };

  function automatic logic [13:0] base_of(input logic [15:0] a);
    return {a[15:4], 2'b00};
  endfunction

  task automatic burst(input logic [15:0] a, input logic [3:0] mask);
    logic [13:0] b;
    b = base_of(a);
    @(negedge clk);
    start = 1'b1; addr = a; ack = 1'b0;
    #1 chk(arr_addr == b, "R3", 32'(arr_addr), 32'(b));
    @(negedge clk);
    start = 1'b0;
    chk(valid && data == word_of(b), "R2", data, word_of(b));
    for (int k = 0; k < 4; k++) begin
      if (mask[k]) begin
        ack = 1'b0;
        @(negedge clk);
        chk(valid && data == word_of(b + 14'(k)), "R5", data, word_of(b + 14'(k)));
      end
      chk(arr_addr[13:2] == b[13:2], "R10", 32'(arr_addr), 32'(b));
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      if (k == 3) chk(!valid, "R6", 32'(valid), 32'd0);
      else chk(valid && data == word_of(b + 14'(k + 1)), "R4", data, word_of(b + 14'(k + 1)));
    end
  endtask

  initial begin
    logic [13:0] nb;
    logic [31:0] held;
    repeat (2) @(negedge clk);
    chk(!valid && data == '0, "R1", data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid && data == '0, "R1", data, 32'd0);

    for (int i = 0; i < 6; i++) burst(VEC[i][19:4], VEC[i][3:0]);

    // R4: continuous accept, words in consecutive cycles
    @(negedge clk);
    start = 1'b1; addr = 16'h2220;
    @(negedge clk);
    start = 1'b0; ack = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk(valid && data == word_of(14'h0888 + 14'(k)), "R4", data, word_of(14'h0888 + 14'(k)));
      @(negedge clk);
    end
    ack = 1'b0;
    chk(!valid, "R6", 32'(valid), 32'd0);

    // R7 / R8: abort mid burst with a start that collides with an accept
    @(negedge clk);
    start = 1'b1; addr = 16'h0310;
    @(negedge clk);
    start = 1'b0; ack = 1'b1;
    @(negedge clk);
    start = 1'b1; addr = 16'h7A5C;
    nb = base_of(16'h7A5C);
    @(negedge clk);
    start = 1'b0;
    chk(valid && data == word_of(nb), "R8", data, word_of(nb));
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      chk(valid && data == word_of(nb + 14'(k)), "R7", data, word_of(nb + 14'(k)));
    end
    @(negedge clk);
    chk(!valid, "R7", 32'(valid), 32'd0);

    // R9: accept while idle
    held = data;
    repeat (3) @(negedge clk);
    chk(!valid && data == held, "R9", data, held);
    ack = 1'b0;

    // R6: stays idle with no start
    repeat (2) @(negedge clk);
    chk(!valid, "R6", 32'(valid), 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule